// File: doc/BRIEF.md
# Multiframe-Aligned Converter Test Sequence Source

This block sits between a two-channel decimated sample path and a serial link transmitter. When its test mode is on, it replaces the live samples with a fixed 32-word sequence on each channel. A receiver that knows the sequence can then confirm three things: that each channel arrives on the right lanes, that samples come out in the right order, and that the multiframe boundary is where it expects it to be. When test mode is off, the live samples pass through. Both modes share the same register stage and the same output number format.

The sequence is locked to a boundary pulse, which is typically derived from the system reference. At each boundary the block restarts at word zero and samples the mode and format controls. A new control setting is therefore never applied part-way through a period. The valid strobe stays low until the first boundary pulse has been seen.

Top module: `mf_test_pattern_gen`

## Requirements
- R1: From reset until the first clock edge that samples `mf_sync_i` high, `smp_vld_o` is 0 and both data outputs are 0x0000.
- R2: From the clock edge that samples `mf_sync_i` high onward, `smp_vld_o` is 1 on every clock.
- R3: In test mode the output repeats with a period of 32 words. Word 0 is the register contents after the edge that sampled the boundary pulse.
- R4: Words 0 and 1 of each period carry the channel tag: 0x0001 on channel A and 0x0002 on channel B.
- R5: On both channels, word 2 of each period is 0x0001 and word 3 is 0x0002.
- R6: Words 4 through 31 of each period are 0x0000 in two's complement format.
- R7: With `fmt_obin_i` = 1 (offset binary), bit 15 of every output word is inverted relative to the two's complement value, so the zero fill reads 0x8000.
- R8: A boundary pulse that arrives mid-period restarts the sequence at word 0 on the next output.
- R9: `tp_en_i` and `fmt_obin_i` are sampled only at word 0 of a period. Changes made at any other word take effect at the next period start.
- R10: With test mode off, each output equals the live input sampled at the previous edge, format-converted as in R7.
- R11: Both channels advance through the sequence on the same clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mf_sync_i | input | 1 | Multiframe boundary pulse |
| tp_en_i | input | 1 | 1 selects the test sequence, 0 selects live samples |
| fmt_obin_i | input | 1 | 1 selects offset binary, 0 selects two's complement |
| live_a_i | input | 16 | Live sample, channel A |
| live_b_i | input | 16 | Live sample, channel B |
| smp_a_o | output | 16 | Output sample, channel A |
| smp_b_o | output | 16 | Output sample, channel B |
| smp_vld_o | output | 1 | Output sample valid |

## Verification
Every output is due exactly one clock after the edge that samples its inputs. This holds for both the pattern words and the pass-through samples, and for the valid strobe as well.

A change of mode or format reaches the outputs only after the next period start plus that one register. This is either a wrap from word 31, or a boundary pulse.

The bench drives inputs on the falling edge. For each cycle it pushes the expected word pair, computed from the requirements, into a queue. The monitor pops one entry 1 ns after each rising edge, so every comparison lands on the first cycle the result can appear.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [1:0] {
        SLOT_TAG,
        SLOT_MARK1,
        SLOT_MARK2,
        SLOT_FILL
    } slot_e;

    // Position of a word within the period decides its content.
    function automatic slot_e slot_of(int unsigned idx);
        if (idx < 2)       return SLOT_TAG;
        else if (idx == 2) return SLOT_MARK1;
        else if (idx == 3) return SLOT_MARK2;
        else               return SLOT_FILL;
    endfunction

endpackage

// File: rtl/tpg_frame_ctrl.sv
module tpg_frame_ctrl #(
    parameter int MF_LEN = 32,
    localparam int CNT_W = $clog2(MF_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             en_i,
    input  logic             fmt_i,
    output logic             active_o,
    output logic [CNT_W-1:0] idx_o,
    output logic             en_eff_o,
    output logic             fmt_eff_o,
    output logic             synced_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             synced;
        logic             en;
        logic             fmt;
    } state_t;

    state_t st_d, st_q;
    logic   active_d, boundary_d, en_eff_d, fmt_eff_d;
    logic [CNT_W-1:0] idx_d;

    always_comb begin
        active_d   = sync_i | st_q.synced;
        idx_d      = sync_i ? '0 : st_q.cnt;
        boundary_d = active_d && (idx_d == '0);
        en_eff_d   = boundary_d ? en_i  : st_q.en;
        fmt_eff_d  = boundary_d ? fmt_i : st_q.fmt;

        st_d        = st_q;
        st_d.synced = active_d;
        st_d.en     = en_eff_d;
        st_d.fmt    = fmt_eff_d;
        if (!active_d)
            st_d.cnt = '0;
        else if (idx_d == CNT_W'(MF_LEN - 1))
            st_d.cnt = '0;
        else
            st_d.cnt = idx_d + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o  = active_d;
    assign idx_o     = idx_d;
    assign en_eff_o  = en_eff_d;
    assign fmt_eff_o = fmt_eff_d;
    assign synced_o  = st_q.synced;

    // R1: no valid before a boundary pulse
    p_no_early_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.synced && !sync_i) |=> !st_q.synced);

    // R2: once valid, always valid
    p_valid_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.synced |=> st_q.synced);

    // R8: a pulse restarts the count so the next word is index 1
    p_sync_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (st_q.cnt == CNT_W'(1)));

    // R9: mode and format hold away from the period start
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.synced && !sync_i && st_q.cnt != '0)
        |=> ($stable(st_q.en) && $stable(st_q.fmt)));

endmodule

// File: rtl/tpg_lane.sv
module tpg_lane
    import tpg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5,
    parameter int CH_ID  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic [CNT_W-1:0]  idx_i,
    input  logic              en_i,
    input  logic              fmt_i,
    input  logic [DATA_W-1:0] live_i,
    output logic [DATA_W-1:0] out_o
);

    localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] pat_d, src_d, out_d, out_q;

    always_comb begin
        unique case (slot_of(int'(idx_i)))
            SLOT_TAG:   pat_d = DATA_W'(CH_ID);
            SLOT_MARK1: pat_d = DATA_W'(1);
            SLOT_MARK2: pat_d = DATA_W'(2);
            default:    pat_d = '0;
        endcase
        src_d = en_i ? pat_d : live_i;
        if (!active_i)  out_d = '0;
        else if (fmt_i) out_d = src_d ^ MSB_MASK;
        else            out_d = src_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_o = out_q;

    // R1: outputs stay clear while the block is not yet aligned
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (out_q == '0));

    // R4: the period header carries this channel's tag
    p_header_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && en_i && !fmt_i && idx_i == '0) |=> (out_q == DATA_W'(CH_ID)));

endmodule

// File: rtl/mf_test_pattern_gen.sv
module mf_test_pattern_gen #(
    parameter int DATA_W = 16,
    parameter int MF_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mf_sync_i,
    input  logic              tp_en_i,
    input  logic              fmt_obin_i,
    input  logic [DATA_W-1:0] live_a_i,
    input  logic [DATA_W-1:0] live_b_i,
    output logic [DATA_W-1:0] smp_a_o,
    output logic [DATA_W-1:0] smp_b_o,
    output logic              smp_vld_o
);

    localparam int CNT_W  = $clog2(MF_LEN);
    localparam int NUM_CH = 2;

    logic             active, en_eff, fmt_eff;
    logic [CNT_W-1:0] idx;
    logic [DATA_W-1:0] live_arr [NUM_CH];
    logic [DATA_W-1:0] out_arr  [NUM_CH];

    tpg_frame_ctrl #(.MF_LEN(MF_LEN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (mf_sync_i),
        .en_i      (tp_en_i),
        .fmt_i     (fmt_obin_i),
        .active_o  (active),
        .idx_o     (idx),
        .en_eff_o  (en_eff),
        .fmt_eff_o (fmt_eff),
        .synced_o  (smp_vld_o)
    );

    assign live_arr[0] = live_a_i;
    assign live_arr[1] = live_b_i;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        tpg_lane #(
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W),
            .CH_ID  (c + 1)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (active),
            .idx_i    (idx),
            .en_i     (en_eff),
            .fmt_i    (fmt_eff),
            .live_i   (live_arr[c]),
            .out_o    (out_arr[c])
        );
    end

    assign smp_a_o = out_arr[0];
    assign smp_b_o = out_arr[1];

    // R6: fill words carry nothing below the sign bit on either channel
    p_fill_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && en_eff && idx >= CNT_W'(4))
        |=> (smp_a_o[DATA_W-2:0] == '0 && smp_b_o[DATA_W-2:0] == '0));

endmodule

// File: tb/mf_test_pattern_gen_bench.sv
`timescale 1ns/1ps
module mf_test_pattern_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_s = 1'b0, en_s = 1'b0, fmt_s = 1'b0;
    logic [15:0] la = '0, lb = '0;
    logic [15:0] oa, ob;
    logic        ov;

    always #2.5 clk = ~clk;

    mf_test_pattern_gen u_mf_test_pattern_gen (
        .clk(clk), .rst_n(rst_n), .mf_sync_i(sync_s), .tp_en_i(en_s),
        .fmt_obin_i(fmt_s), .live_a_i(la), .live_b_i(lb),
        .smp_a_o(oa), .smp_b_o(ob), .smp_vld_o(ov)
    );

    typedef struct {
        logic        v;
        logic [15:0] a;
        logic [15:0] b;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;

    // reference state, built from the requirements
    bit m_synced = 0, m_en = 0, m_fmt = 0;
    int m_cnt = 0;

    function automatic logic [15:0] ref_word(int ch, int idx, bit act, bit en,
                                             bit fmt, logic [15:0] live);
        logic [15:0] w;
        if (!act) return 16'h0000;
        if (!en)              w = live;        // R10
        else if (idx < 2)     w = 16'(ch);     // R4
        else if (idx == 2)    w = 16'h0001;    // R5
        else if (idx == 3)    w = 16'h0002;    // R5
        else                  w = 16'h0000;    // R6
        if (fmt) w[15] = ~w[15];               // R7
        return w;
    endfunction

    task automatic step(bit s, bit e, bit f, logic [15:0] a, logic [15:0] b, string tag);
        exp_t x;
        bit   act;
        int   idx;
        @(negedge clk);
        sync_s = s; en_s = e; fmt_s = f; la = a; lb = b;
        act = s || m_synced;
        idx = s ? 0 : m_cnt;
        if (act && idx == 0) begin m_en = e; m_fmt = f; end   // R9
        x.v   = act;
        x.a   = ref_word(1, idx, act, m_en, m_fmt, a);
        x.b   = ref_word(2, idx, act, m_en, m_fmt, b);
        x.tag = tag;
        m_cnt    = act ? (idx + 1) % 32 : 0;                   // R3
        m_synced = act;
        q.push_back(x);
    endtask

    // monitor: compares one entry per rising edge, 1 ns after it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                n_chk++;
                if (ov !== x.v || oa !== x.a || ob !== x.b) begin
                    n_fail++;
                    $display("FAIL %s: vld=%0b a=%h b=%h expected vld=%0b a=%h b=%h",
                             x.tag, ov, oa, ob, x.v, x.a, x.b);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic logic [15:0] live_val(int i, int salt);
        return 16'((i * 16'h03C5 + 16'h8123) ^ (salt * 16'h1F0F));
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_chk++;   // R1 reset state
        if (ov !== 1'b0 || oa !== 16'h0 || ob !== 16'h0) begin
            n_fail++;
            $display("FAIL R1 reset: vld=%0b a=%h b=%h expected vld=0 a=0000 b=0000", ov, oa, ob);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: no boundary pulse yet, outputs stay idle
        for (int i = 0; i < 5; i++) step(0, 1, 0, live_val(i, 1), live_val(i, 2), "R1");

        // R2 R3 R4 R5 R6 R11: aligned sequence, two's complement
        step(1, 1, 0, 16'h1111, 16'h2222, "R2 R3 R4 R11");
        for (int i = 0; i < 69; i++)
            step(0, 1, 0, live_val(i, 3), live_val(i, 4), "R2 R3 R4 R5 R6 R11");

        // R7 R9: format raised mid-period, applies at the next start
        for (int i = 0; i < 40; i++)
            step(0, 1, 1, live_val(i, 5), live_val(i, 6), "R7 R9");

        // R9 R10: test mode dropped mid-period, pass-through from next start
        for (int i = 0; i < 40; i++)
            step(0, 0, 1, live_val(i, 7), live_val(i, 8), "R9 R10");

        // R8: pulse mid-period realigns with test mode back on
        step(1, 1, 1, 16'hAAAA, 16'h5555, "R8");
        for (int i = 0; i < 39; i++)
            step(0, 1, 1, live_val(i, 9), live_val(i, 10), "R8 R7");

        // R10: pass-through in two's complement
        for (int i = 0; i < 40; i++)
            step(0, 0, 0, live_val(i, 11), live_val(i, 12), "R10");

        repeat (4) @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule